// File: doc/BRIEF.md
# I2C Slave Register File Interface

This block is the serial front end of a timekeeping subsystem. It sits on a two-wire I2C bus as a slave at the fixed 7-bit address 1101000. Through it a bus master reaches a 17-byte register space, 00h to 10h. Bytes 00h to 06h hold the current time. They are owned by an external timekeeper core, so a write to one of them leaves the block on a one-cycle write port. Bytes 07h to 10h are stored inside the block and are driven out in parallel to the logic they configure.

Both bus lines are oversampled on the system clock through synchronisers. The system clock must run at least ten times faster than SCL. The block pulls SDA low only through an open-drain enable.

A write transaction starts with the address byte. The first data byte after it loads the register pointer, and every later byte is stored at the pointer, which then advances. A read streams bytes from the pointer, which also advances after each byte. The pointer runs from 10h back round to 00h. Reads of the time bytes never see the live time directly. They are served from a 7-byte snapshot, and the snapshot is refreshed on every START, every STOP and every pointer wrap, so a burst read always returns one consistent instant.

Top module: `i2c_regfile_slave`

## Requirements
- R1: Address byte 0xD0 (write) and address byte 0xD1 (read) are acknowledged. Any other address byte gets no acknowledge. After it, SDA stays released and no register changes until the next START.
- R2: In a write, the first byte after the address loads the pointer. Each later byte is acknowledged and stored at the pointer, which then increments. Register 07h+k appears at cfg_o[8k+7:8k]. A write to byte k of 00h–06h pulses time_we_o for one cycle with time_waddr_o = k and time_wdata_o = the data byte.
- R3: The pointer steps from 10h to 00h, in both reads and writes. A pointer byte above 10h loads the pointer with 00h.
- R4: The time snapshot takes the value of time_i on every START, STOP and pointer wrap. Byte k of time_i is time_i[8k+7:8k]. A read of register k in 00h–06h returns byte k of the snapshot, even if time_i changes during the burst.
- R5: A read that has no pointer write in front of it starts at the pointer left by the previous transaction. The pointer survives STOP.
- R6: Read data goes out MSB first, and reading continues while the master acknowledges. After a master NACK the slave releases SDA and drives nothing until the next START. SDA changes only after SCL falls, or on START or STOP.
- R7: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A repeated START begins a new address phase without a STOP.
- R8: A written byte takes effect during the slave's acknowledge clock, before the master sends the next byte.
- R9: After reset SDA is released, the pointer is 00h, registers 07h–10h are zero and no time write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| time_i | input | 56 | Live time bytes 00h–06h from the timekeeper |
| time_we_o | output | 1 | One-cycle write strobe for a time byte |
| time_waddr_o | output | 3 | Time byte index being written |
| time_wdata_o | output | 8 | Time byte value being written |
| cfg_o | output | 80 | Stored registers 07h–10h, 07h in the low byte |

## Verification
A wrong pointer or a wrong shift count shows within one byte time. Either the data read back, including its bit order, differs from what was written at that address, or the acknowledge falls on the wrong clock. A stale or early snapshot shows as time bytes that belong to a value of time_i which was never present at a START, STOP or wrap, so the bench changes time_i in the middle of bursts. A slave that fails to go idle after a NACK or a foreign address shows in the very next SCL low phase: it holds SDA low, and the bench arranges a following data bit of 0 so that this is visible.

// File: rtl/i2c_regfile_pkg.sv
package i2c_regfile_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ADDR_ACK = 3'd2,
        ST_WR       = 3'd3,
        ST_WR_ACK   = 3'd4,
        ST_RD       = 3'd5,
        ST_RD_ACK   = 3'd6
    } i2c_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    logic scl_s, sda_s;
    assign scl_s = q.scl_pipe[STAGES-1];
    assign sda_s = q.sda_pipe[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl_pipe <= '1;
            q.sda_pipe <= '1;
            q.scl_prev <= 1'b1;
            q.sda_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_o      = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_prev;
    assign scl_fall_o = ~scl_s & q.scl_prev;
    assign start_o    = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_o     = scl_s & q.scl_prev & ~q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
    import i2c_regfile_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         NUM_REGS = 17,
    parameter int         PTR_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             sda_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       rd_data_i,
    output logic             sda_oe_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_en_o,
    output logic [7:0]       wr_data_o,
    output logic             wrap_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

    typedef struct packed {
        i2c_state_e       st;
        logic [3:0]       cnt;
        logic [7:0]       sr;
        logic             rw;
        logic             first;
        logic [PTR_W-1:0] ptr;
        logic             oe;
        logic             mack;
    } ctrl_t;

    ctrl_t q, d;
    logic wr_en_c, inc_c;
    logic [PTR_W-1:0] ptr_next;

    assign ptr_next = (q.ptr == LAST) ? '0 : q.ptr + PTR_W'(1);

    always_comb begin
        d       = q;
        wr_en_c = 1'b0;
        inc_c   = 1'b0;
        if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_i) begin
            d.st  = ST_ADDR;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise_i) begin
                        d.sr  = {q.sr[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall_i && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sr[7:1] == DEV_ADDR) begin
                                d.st = ST_ADDR_ACK;
                                d.oe = 1'b1;
                                d.rw = q.sr[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st = ST_WR_ACK;
                            d.oe = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = 4'd0;
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.sr = rd_data_i;
                            d.oe = ~rd_data_i[7];
                        end else begin
                            d.st    = ST_WR;
                            d.oe    = 1'b0;
                            d.first = 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_rise_i) begin
                        if (q.first) begin
                            d.ptr = (q.sr > 8'(NUM_REGS - 1)) ? '0 : q.sr[PTR_W-1:0];
                        end else begin
                            wr_en_c = 1'b1;
                            inc_c   = 1'b1;
                            d.ptr   = ptr_next;
                        end
                    end else if (scl_fall_i) begin
                        d.st    = ST_WR;
                        d.oe    = 1'b0;
                        d.cnt   = 4'd0;
                        d.first = 1'b0;
                    end
                end
                ST_RD: begin
                    if (scl_fall_i) begin
                        if (q.cnt == 4'd7) begin
                            d.st  = ST_RD_ACK;
                            d.oe  = 1'b0;
                            d.cnt = 4'd0;
                            inc_c = 1'b1;
                            d.ptr = ptr_next;
                        end else begin
                            d.sr  = {q.sr[6:0], 1'b0};
                            d.oe  = ~q.sr[6];
                            d.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall_i) begin
                        if (q.mack) begin
                            d.st  = ST_RD;
                            d.sr  = rd_data_i;
                            d.oe  = ~rd_data_i[7];
                            d.cnt = 4'd0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o  = q.oe;
    assign ptr_o     = q.ptr;
    assign wr_en_o   = wr_en_c;
    assign wr_data_o = q.sr;
    assign wrap_o    = inc_c && (q.ptr == LAST);

    // R1: foreign address drops the slave to idle with SDA released
    p_nomatch_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && scl_fall_i && q.cnt == 4'd8 && q.sr[7:1] != DEV_ADDR
         && !start_i && !stop_i) |=> (q.st == ST_IDLE && !q.oe));

    // R3: pointer advancing from the last register lands on zero
    p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_c && q.ptr == LAST && !start_i && !stop_i) |=> (q.ptr == '0));

    // R6: SDA drive changes only after an SCL fall or a bus condition
    p_oe_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall_i || start_i || stop_i));

    // R6: STOP leaves SDA released
    p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !q.oe);

    // R7: START always opens an address phase
    p_start_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (q.st == ST_ADDR && q.cnt == 4'd0));

endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store #(
    parameter int NUM_REGS   = 17,
    parameter int TIME_BYTES = 7,
    parameter int PTR_W      = 5
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en_i,
    input  logic [PTR_W-1:0]                     wr_addr_i,
    input  logic [7:0]                           wr_data_i,
    input  logic                                 snap_i,
    input  logic [TIME_BYTES*8-1:0]              time_i,
    input  logic [PTR_W-1:0]                     rd_addr_i,
    output logic [7:0]                           rd_data_o,
    output logic [(NUM_REGS-TIME_BYTES)*8-1:0]   cfg_o,
    output logic                                 time_we_o,
    output logic [$clog2(TIME_BYTES)-1:0]        time_waddr_o,
    output logic [7:0]                           time_wdata_o
);

    localparam int CFG_N = NUM_REGS - TIME_BYTES;
    localparam int TW    = $clog2(TIME_BYTES);
    localparam int CW    = $clog2(CFG_N);

    typedef struct packed {
        logic [TIME_BYTES-1:0][7:0] shadow;
        logic [CFG_N-1:0][7:0]      cfg;
    } store_t;

    store_t q, d;
    logic [CW-1:0] rd_off;

    always_comb begin
        d = q;
        if (snap_i) d.shadow = time_i;
        for (int i = 0; i < CFG_N; i++) begin
            if (wr_en_i && wr_addr_i == PTR_W'(TIME_BYTES + i)) d.cfg[i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_off = CW'(rd_addr_i - PTR_W'(TIME_BYTES));
        if (rd_addr_i < PTR_W'(TIME_BYTES)) rd_data_o = q.shadow[rd_addr_i[TW-1:0]];
        else                                rd_data_o = q.cfg[rd_off];
    end

    assign cfg_o        = q.cfg;
    assign time_we_o    = wr_en_i && (wr_addr_i < PTR_W'(TIME_BYTES));
    assign time_waddr_o = wr_addr_i[TW-1:0];
    assign time_wdata_o = wr_data_i;

    // R4: snapshot takes the live time present on the capture cycle
    p_snap_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (q.shadow == $past(time_i)));

    // R4: snapshot holds between capture events
    p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(q.shadow));

    // R2: stored registers change only on a write
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(q.cfg));

    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg_chk
        // R2: a write to this register lands on the next cycle
        p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == PTR_W'(TIME_BYTES + g)) |=> (q.cfg[g] == $past(wr_data_i)));
    end

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NUM_REGS    = 17,
    parameter int         TIME_BYTES  = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 scl_i,
    input  logic                                 sda_i,
    output logic                                 sda_oe_o,
    input  logic [TIME_BYTES*8-1:0]              time_i,
    output logic                                 time_we_o,
    output logic [$clog2(TIME_BYTES)-1:0]        time_waddr_o,
    output logic [7:0]                           time_wdata_o,
    output logic [(NUM_REGS-TIME_BYTES)*8-1:0]   cfg_o
);

    localparam int PTR_W = $clog2(NUM_REGS);

    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [PTR_W-1:0] ptr;
    logic wr_en, wrap;
    logic [7:0] wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2c_slave_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_i      (sda_s),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .rd_data_i  (rd_data),
        .sda_oe_o   (sda_oe_o),
        .ptr_o      (ptr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .wrap_o     (wrap)
    );

    i2c_reg_store #(
        .NUM_REGS   (NUM_REGS),
        .TIME_BYTES (TIME_BYTES),
        .PTR_W      (PTR_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (ptr),
        .wr_data_i    (wr_data),
        .snap_i       (bus_start | bus_stop | wrap),
        .time_i       (time_i),
        .rd_addr_i    (ptr),
        .rd_data_o    (rd_data),
        .cfg_o        (cfg_o),
        .time_we_o    (time_we_o),
        .time_waddr_o (time_waddr_o),
        .time_wdata_o (time_wdata_o)
    );

endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;

    localparam int HP = 20;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        scl_m, sda_m;
    logic        sda_oe;
    logic [55:0] time_v;
    logic        time_we;
    logic [2:0]  time_waddr;
    logic [7:0]  time_wdata;
    logic [79:0] cfg;
    wire         sda_line = sda_m & ~sda_oe;

    i2c_regfile_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .time_i       (time_v),
        .time_we_o    (time_we),
        .time_waddr_o (time_waddr),
        .time_wdata_o (time_wdata),
        .cfg_o        (cfg)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int         tw_cnt  = 0;
    logic [2:0] tw_addr = '0;
    logic [7:0] tw_data = '0;
    always @(posedge clk) begin
        if (time_we) begin
            tw_cnt  <= tw_cnt + 1;
            tw_addr <= time_waddr;
            tw_data <= time_wdata;
        end
    end

    localparam logic [15:0] VEC [8] = '{
        16'h07A5, 16'h083C, 16'h09FF, 16'h0A00,
        16'h0C81, 16'h0E5A, 16'h0FC3, 16'h107E
    };

    logic       ack;
    logic [7:0] rb;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b0; wt(HP);
        scl_m = 1'b0; wt(HP/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        sda_m = 1'b1; wt(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(HP/2);
            scl_m = 1'b1; wt(HP);
            scl_m = 1'b0; wt(HP/2);
        end
        sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP/2);
        a = ~sda_line; wt(HP/2);
        scl_m = 1'b0; wt(HP/2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(HP/2);
            scl_m = 1'b1; wt(HP/2);
            b[i] = sda_line; wt(HP/2);
            scl_m = 1'b0; wt(HP/2);
        end
        sda_m = ~mack; wt(HP/2);
        scl_m = 1'b1; wt(HP);
        scl_m = 1'b0; wt(HP/2);
        sda_m = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        scl_m  = 1'b1;
        sda_m  = 1'b1;
        time_v = 56'h0;
        wt(10);
        rst_n = 1'b1;
        wt(10);

        // R9: reset state
        chk("R9 sda released", 64'(sda_oe), 64'd0);
        chk("R9 cfg zero", 64'(cfg), 64'd0);
        chk("R9 no time write", 64'(tw_cnt), 64'd0);

        // Table: write one register, then read it back with a repeated START
        for (int v = 0; v < 8; v++) begin
            logic [7:0] a8, d8;
            a8 = VEC[v][15:8];
            d8 = VEC[v][7:0];
            bus_start();
            send_byte(8'hD0, ack);
            chk("R1 write address ack", 64'(ack), 64'd1);
            send_byte(a8, ack);
            send_byte(d8, ack);
            chk("R2 data ack", 64'(ack), 64'd1);
            // R8: visible right after the acknowledge clock
            chk("R8 commit on ack", 64'(cfg[(a8-8'd7)*8 +: 8]), 64'(d8));
            bus_stop();
            bus_start();
            send_byte(8'hD0, ack);
            send_byte(a8, ack);
            bus_start();
            send_byte(8'hD1, ack);
            chk("R7 read address ack after repeated START", 64'(ack), 64'd1);
            recv_byte(rb, 1'b0);
            chk("R6 read back MSB first", 64'(rb), 64'(d8));
            chk("R6 released after NACK", 64'(sda_oe), 64'd0);
            bus_stop();
        end

        // R2/R3: burst write across the top of the map into time bytes
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h0E, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        chk("R2 burst cfg 0E-10", 64'(cfg[79:56]), 64'h332211);
        send_byte(8'h44, ack);
        chk("R3 write wrap to 00", 64'({tw_addr, tw_data}), 64'({3'd0, 8'h44}));
        send_byte(8'h55, ack);
        chk("R2 time write 01", 64'({tw_addr, tw_data}), 64'({3'd1, 8'h55}));
        chk("R2 time write count", 64'(tw_cnt), 64'd2);
        bus_stop();

        // R1: foreign and near-miss addresses are ignored
        bus_start();
        send_byte(8'hA0, ack);
        chk("R1 foreign address nack", 64'(ack), 64'd0);
        send_byte(8'h07, ack);
        chk("R1 no ack while idle", 64'(ack), 64'd0);
        send_byte(8'h99, ack);
        chk("R1 sda released while idle", 64'(sda_oe), 64'd0);
        bus_stop();
        chk("R1 register untouched", 64'(cfg[7:0]), 64'hA5);
        bus_start();
        send_byte(8'hD2, ack);
        chk("R1 near-miss address nack", 64'(ack), 64'd0);
        bus_stop();

        // R3: out-of-range pointer byte loads 00h
        time_v = 56'h66_55_44_33_22_11_10;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h1F, ack);
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(rb, 1'b0);
        chk("R3 pointer above 10h reads 00h", 64'(rb), 64'h10);
        bus_stop();

        // R4: burst read stays on the START snapshot while time moves
        time_v = 56'hA6_A5_A4_A3_A2_A1_A0;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h00, ack);
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(rb, 1'b1);
        chk("R4 snapshot byte 0", 64'(rb), 64'hA0);
        time_v = 56'hB6_B5_B4_B3_B2_B1_B0;
        recv_byte(rb, 1'b1);
        chk("R4 snapshot byte 1 coherent", 64'(rb), 64'hA1);
        recv_byte(rb, 1'b0);
        chk("R4 snapshot byte 2 coherent", 64'(rb), 64'hA2);
        bus_stop();

        // R5: read with no pointer write continues at 03h, snapshot from this START
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(rb, 1'b0);
        chk("R5 resumes at stored pointer", 64'(rb), 64'hB3);
        bus_stop();

        // R3/R4: read through the wrap refreshes the snapshot
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h0F, ack);
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(rb, 1'b1);
        chk("R3 read 0F", 64'(rb), 64'h22);
        time_v = 56'hC6_C5_C4_C3_C2_C1_C0;
        recv_byte(rb, 1'b1);
        chk("R3 read 10", 64'(rb), 64'h33);
        recv_byte(rb, 1'b0);
        chk("R4 wrap snapshot byte 0", 64'(rb), 64'hC0);
        bus_stop();

        // R5: pointer kept across STOP after the wrap
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(rb, 1'b0);
        chk("R5 resume after wrap", 64'(rb), 64'hC1);
        chk("R6 released after final NACK", 64'(sda_oe), 64'd0);
        bus_stop();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule